// File: doc/BRIEF.md
# Dual-Field Four-Segment Karatsuba Multiplier

This block multiplies two W-bit operands and returns the full 2W-bit product. A mode input selects the kind of product. Integer mode gives the ordinary product, for use in prime-field arithmetic. Binary mode gives the carry-less polynomial product over GF(2), for use in binary extension fields. Modular reduction is outside the block and belongs to the logic that consumes the product.

Each operand is cut into four segments of S = W/4 bits. Two levels of Karatsuba decomposition turn the product into nine segment-level sub-products. A single shared segment multiplier computes one sub-product per clock cycle, for nine cycles in total. The schoolbook schedule would need sixteen. The block adds each sub-product into the product register at its fixed shifts, each with its own sign, so no partial results are kept between levels. In binary mode the sums become XOR and the sign no longer matters.

Control uses a start/busy/done handshake. Operands and mode are registered when a start is accepted.

Top module: `dual_field_kmul`

## Requirements
- R1: With mode_i = 0 (integer), product_o at the done pulse equals the unsigned integer product a*b, all 2W bits, for any operands.
- R2: With mode_i = 1 (binary), product_o at the done pulse equals the carry-less product: the XOR of (a << i) over every bit i set in b.
- R3: a_i, b_i and mode_i are sampled only at the rising edge where an idle block sees start_i high. Later changes to them do not alter the result.
- R4: After the accepting edge, busy_o is high for exactly nine cycles. done_o is high for exactly one cycle, the cycle right after busy_o falls.
- R5: While busy_o is high, start_i is ignored. The result and the done timing are those of the run already in progress.
- R6: An accepted start clears product_o to zero. After the done pulse, product_o holds the result until the next accepted start.
- R7: During and after reset, busy_o, done_o and product_o are all zero.
- R8: The all-ones and all-zero operands give exact results in both modes, including the largest integer product (2^W - 1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication; accepted only when idle |
| mode_i | input | 1 | 0 = integer product, 1 = carry-less product |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle pulse when product_o becomes valid |
| product_o | output | 2*W | Full-width product |

## Verification
The timing and hold assertions assume that the input pins are known at each clock edge. They also assume that start_i is a level the block samples on every cycle, and that nothing outside the block clears it. The bench drives every input on the falling edge, so values never change near a sampling edge. It raises start_i only after busy_o is seen low, except on purpose inside a run, to check that the start is ignored. On the cycle after acceptance, the bench scrambles the operand and mode pins so that the result depends on the captured copy alone. The seeded random operands span the full width, so sums of segments carry in integer mode. The all-ones operands reach the carry limits of each sum and of the accumulation.

// File: rtl/kmul_pkg.sv
package kmul_pkg;

  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_BIN = 1'b1
  } kmul_mode_e;

  localparam int unsigned NSHIFT = 7;

  typedef logic [NSHIFT-1:0] shmask_t;

  typedef struct packed {
    shmask_t pos;
    shmask_t neg;
  } coef_t;

  // Shift weights (in segments) of one sub-product.
  // grp: 0 = low half, 1 = high half, 2 = half-sum.
  // sub: 0 = low seg, 1 = high seg, 2 = seg-sum.
  function automatic coef_t step_coef(logic [1:0] grp, logic [1:0] sub);
    logic [4:0] gp, gn;
    logic [2:0] sp, sn;
    coef_t c;
    case (grp)
      2'd0:    begin gp = 5'b00001; gn = 5'b00100; end
      2'd1:    begin gp = 5'b10000; gn = 5'b00100; end
      default: begin gp = 5'b00100; gn = 5'b00000; end
    endcase
    case (sub)
      2'd0:    begin sp = 3'b001; sn = 3'b010; end
      2'd1:    begin sp = 3'b100; sn = 3'b010; end
      default: begin sp = 3'b010; sn = 3'b000; end
    endcase
    c = '0;
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 3; j++) begin
        c.pos[i+j] = c.pos[i+j] | (gp[i] & sp[j]) | (gn[i] & sn[j]);
        c.neg[i+j] = c.neg[i+j] | (gp[i] & sn[j]) | (gn[i] & sp[j]);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/kmul_opsel.sv
module kmul_opsel #(
  parameter int unsigned S = 64
) (
  input  logic [4*S-1:0] a_i,
  input  logic [4*S-1:0] b_i,
  input  logic           bin_i,
  input  logic [1:0]     grp_i,
  input  logic [1:0]     sub_i,
  output logic [S+1:0]   x_o,
  output logic [S+1:0]   y_o
);

  function automatic logic [S+1:0] pick(logic [4*S-1:0] v, logic bin,
                                        logic [1:0] grp, logic [1:0] sub);
    logic [2*S:0] half;
    logic [S-1:0] u0;
    logic [S:0]   u1;
    logic [S+1:0] um;
    case (grp)
      2'd0:    half = {1'b0, v[2*S-1:0]};
      2'd1:    half = {1'b0, v[4*S-1:2*S]};
      default: half = bin ? {1'b0, v[4*S-1:2*S] ^ v[2*S-1:0]}
                          : {1'b0, v[4*S-1:2*S]} + {1'b0, v[2*S-1:0]};
    endcase
    u0 = half[S-1:0];
    u1 = half[2*S:S];
    um = bin ? {1'b0, u1 ^ {1'b0, u0}}
             : {1'b0, u1} + {2'b00, u0};
    case (sub)
      2'd0:    return {2'b00, u0};
      2'd1:    return {1'b0, u1};
      default: return um;
    endcase
  endfunction

  assign x_o = pick(a_i, bin_i, grp_i, sub_i);
  assign y_o = pick(b_i, bin_i, grp_i, sub_i);

endmodule

// File: rtl/kmul_segmul.sv
module kmul_segmul #(
  parameter int unsigned N = 66
) (
  input  logic           bin_i,
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [2*N-1:0] p_o
);

  logic [2*N-1:0] p_int, p_clm;

  assign p_int = {{N{1'b0}}, x_i} * {{N{1'b0}}, y_i};

  always_comb begin
    p_clm = '0;
    for (int i = 0; i < N; i++) begin
      if (y_i[i]) p_clm = p_clm ^ ({{N{1'b0}}, x_i} << i);
    end
  end

  assign p_o = bin_i ? p_clm : p_int;

endmodule

// File: rtl/kmul_acc.sv
module kmul_acc
  import kmul_pkg::*;
#(
  parameter int unsigned S  = 64,
  parameter int unsigned QW = 2*S+4,
  parameter int unsigned AW = 8*S
) (
  input  logic [AW-1:0] acc_i,
  input  logic [QW-1:0] q_i,
  input  coef_t         coef_i,
  input  logic          bin_i,
  output logic [AW-1:0] acc_o
);

  logic [AW-1:0] q_ext;
  assign q_ext = {{(AW-QW){1'b0}}, q_i};

  // Integer sums wrap modulo 2^AW; the final total always fits.
  always_comb begin
    logic [AW-1:0] term;
    acc_o = acc_i;
    for (int i = 0; i < int'(NSHIFT); i++) begin
      term = q_ext << (i*S);
      if (bin_i) begin
        if (coef_i.pos[i] | coef_i.neg[i]) acc_o = acc_o ^ term;
      end else begin
        if (coef_i.pos[i]) acc_o = acc_o + term;
        if (coef_i.neg[i]) acc_o = acc_o - term;
      end
    end
  end

endmodule

// File: rtl/dual_field_kmul.sv
module dual_field_kmul
  import kmul_pkg::*;
#(
  parameter int unsigned W = 256
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);

  localparam int unsigned S  = W/4;
  localparam int unsigned QN = S+2;
  localparam int unsigned QW = 2*QN;
  localparam int unsigned AW = 2*W;

  logic [W-1:0]  a_q, b_q;
  kmul_mode_e    mode_q;
  logic          busy_q, done_q;
  logic [1:0]    grp_q, sub_q;
  logic [AW-1:0] acc_q, acc_d;
  logic [QN-1:0] x, y;
  logic [QW-1:0] q;
  logic          bin;
  logic          last;
  coef_t         coef;

  assign bin  = (mode_q == MODE_BIN);
  assign coef = step_coef(grp_q, sub_q);
  assign last = (grp_q == 2'd2) && (sub_q == 2'd2);

  kmul_opsel #(.S(S)) u_opsel (
    .a_i   (a_q),
    .b_i   (b_q),
    .bin_i (bin),
    .grp_i (grp_q),
    .sub_i (sub_q),
    .x_o   (x),
    .y_o   (y)
  );

  kmul_segmul #(.N(QN)) u_segmul (
    .bin_i (bin),
    .x_i   (x),
    .y_i   (y),
    .p_o   (q)
  );

  kmul_acc #(.S(S), .QW(QW), .AW(AW)) u_acc (
    .acc_i  (acc_q),
    .q_i    (q),
    .coef_i (coef),
    .bin_i  (bin),
    .acc_o  (acc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= MODE_INT;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      grp_q  <= '0;
      sub_q  <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        a_q    <= a_i;
        b_q    <= b_i;
        mode_q <= kmul_mode_e'(mode_i);
        busy_q <= 1'b1;
        grp_q  <= '0;
        sub_q  <= '0;
        acc_q  <= '0;
      end else if (busy_q) begin
        acc_q <= acc_d;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          grp_q  <= '0;
          sub_q  <= '0;
        end else if (sub_q == 2'd2) begin
          sub_q <= '0;
          grp_q <= grp_q + 2'd1;
        end else begin
          sub_q <= sub_q + 2'd1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign product_o = acc_q;

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r4_nine_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(busy_q, 1) && $past(busy_q, 9) && !$past(busy_q, 10)));

  a_r4_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);

  a_r5_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(mode_q)));

  a_r6_product_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(acc_q));

  a_r6_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> (acc_q == '0));

  a_r1_seg_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (q[0] == (x[0] & y[0])));

  a_r2_clmul_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bin) |-> ((^q) == ((^x) & (^y))));

endmodule

// File: tb/dual_field_kmul_test.sv
module dual_field_kmul_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned W = 256;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic           mode_i = 1'b0;
  logic [W-1:0]   a_i = '0;
  logic [W-1:0]   b_i = '0;
  logic           busy_o, done_o;
  logic [2*W-1:0] product_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  dual_field_kmul #(.W(W)) uut (
    .clk_i, .rst_ni, .start_i, .mode_i, .a_i, .b_i,
    .busy_o, .done_o, .product_o
  );

  function automatic logic [W-1:0] rnd_op();
    logic [W-1:0] r;
    for (int k = 0; k < W/32; k++) r[k*32 +: 32] = $urandom();
    return r;
  endfunction

  function automatic logic [2*W-1:0] ref_int(logic [W-1:0] a, logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  function automatic logic [2*W-1:0] ref_clm(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] r = '0;
    for (int i = 0; i < W; i++) if (b[i]) r = r ^ ({{W{1'b0}}, a} << i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic md, input bit poke, input string tag);
    logic [2*W-1:0] exp;
    bit seq_ok;
    exp = md ? ref_clm(a, b) : ref_int(a, b);
    while (busy_o) @(negedge clk_i);
    a_i = a; b_i = b; mode_i = md; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    a_i = rnd_op(); b_i = rnd_op(); mode_i = ~md;   // R3 scramble
    chk(busy_o && !done_o && product_o == '0, "R6 clear on start",
        product_o, '0);
    seq_ok = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      start_i = poke && (c == 3);                  // R5 start while busy
      if (poke && c == 3) begin a_i = rnd_op(); b_i = ~b; end
      @(negedge clk_i);
      seq_ok = seq_ok && busy_o && !done_o;
    end
    start_i = 1'b0;
    chk(seq_ok, "R4 busy span", {511'd0, seq_ok}, {511'd0, 1'b1});
    @(negedge clk_i);
    chk(done_o && !busy_o, "R4 done timing", {510'd0, done_o, busy_o},
        {510'd0, 2'b10});
    chk(product_o == exp, tag, product_o, exp);
    @(negedge clk_i);
    chk(!done_o && product_o == exp, "R6 hold after done", product_o, exp);
  endtask

  initial begin
    #1ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && product_o == '0, "R7 reset state",
        product_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && product_o == '0, "R7 after reset",
        product_o, '0);

    // R8 corners
    run('0, '0, 1'b0, 1'b0, "R8 int zero");
    run('1, '1, 1'b0, 1'b0, "R8 R1 int all-ones");
    run('1, '1, 1'b1, 1'b0, "R8 R2 bin all-ones");
    run('1, '0, 1'b1, 1'b0, "R8 bin ones x zero");
    run('1, W'(1), 1'b0, 1'b0, "R8 R1 int ones x one");

    // R5 ignored start mid-run
    run(rnd_op(), rnd_op(), 1'b0, 1'b1, "R5 R1 int poke");
    run(rnd_op(), rnd_op(), 1'b1, 1'b1, "R5 R2 bin poke");

    for (int n = 0; n < 12; n++) begin
      run(rnd_op(), rnd_op(), 1'b0, 1'b0, "R1 R3 int random");
      run(rnd_op(), rnd_op(), 1'b1, 1'b0, "R2 R3 bin random");
    end

    // idle start-free cycles keep the product (R6)
    begin
      logic [2*W-1:0] held;
      held = product_o;
      a_i = rnd_op();
      repeat (4) @(negedge clk_i);
      chk(product_o == held && !busy_o, "R6 idle hold", product_o, held);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule